// File: doc/BRIEF.md
# Two-Word Branch Target Cache

This block sits in an instruction fetch unit whose code comes from slow external memory. It owns the sequential fetch pointer and keeps a single cache entry. The entry holds the address of the last taken jump of a cacheable kind, plus the two instruction words that the bus returned from that jump's target. When the same single-word relative jump is taken again, the two stored words go straight to the prefetch queue, with no wait on the bus. The pointer meanwhile jumps to the target plus four bytes, so bus fetching resumes behind the replayed words.

The decoder reports every control-flow redirect as one event. The event carries a kind code, the address of the jump instruction, the target, and a flag that marks code running from internal memory. Relative, absolute and bit-test jumps from external code load the entry. The fourth kind stands for any other redirect: calls, returns, segment changes and interrupt entry. This fourth kind, and any jump from internal code, invalidate the entry. On the bus side, every acknowledged cycle either returns the word at the fetch pointer or, when flagged as a data transfer cycle, belongs to some other bus master and must be ignored.

Top module: `branch_target_cache`

## Requirements
- R1: A cycle with `rst` high, sampled at a clock edge, leaves the entry invalid, `fetch_addr` at `RESET_ADDR`, `fetch_req` high, and `pq_vld` and `cache_hit` low.
- R2: With no jump event, a cycle with `bus_ack` high, `bus_xfer` low and `fetch_req` high is an accepted fetch. One cycle later its `bus_rdata` appears on `pq_word` with `pq_vld` high, and `fetch_addr` has advanced by 2.
- R3: A jump event (`jmp_vld` high) that does not hit sets `fetch_addr` to `jmp_target` one cycle later. Any word acknowledged in the same cycle is discarded, and `pq_vld` is low one cycle later.
- R4: A jump event of kind 0 (relative), 1 (absolute) or 2 (bit-test) with `jmp_internal` low that misses records `jmp_pc` as the tag. The next two accepted fetches are stored as target words A and A+2. The entry becomes valid only after the second word is stored.
- R5: A jump event of kind 0 with `jmp_internal` low, a valid entry and `jmp_pc` equal to the tag is a hit. One cycle later `cache_hit` is high. In the following two cycles `pq_word` carries the stored words for A and then A+2. `fetch_req` is low for the two cycles after the event.
- R6: After a hit, `fetch_addr` equals `jmp_target` + 4. The first word fetched from the bus after the replay is the one at A+4, never A+2.
- R7: A jump event of kind 1 never hits, even with a matching tag; it reloads the entry.
- R8: A jump event with `jmp_internal` high never hits and leaves the entry invalid.
- R9: A jump event of kind 3 invalidates the entry and aborts any fill in progress.
- R10: An acknowledged cycle with `bus_xfer` high leaves `fetch_addr` unchanged, produces no `pq_vld`, and stores no word in the entry.
- R11: A cacheable jump at a different address replaces the entry, so the earlier jump misses when it is taken next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jmp_vld | input | 1 | A control-flow redirect is taken this cycle |
| jmp_kind | input | 2 | 0 relative, 1 absolute, 2 bit-test, 3 other redirect |
| jmp_pc | input | AW | Address of the jump instruction |
| jmp_target | input | AW | Byte address of the target |
| jmp_internal | input | 1 | The jump runs from internal memory |
| bus_ack | input | 1 | The bus completes a cycle |
| bus_xfer | input | 1 | The completed cycle is a data transfer, not a fetch |
| bus_rdata | input | DW | Word returned by the bus |
| fetch_addr | output | AW | Byte address of the next instruction fetch |
| fetch_req | output | 1 | The block wants a bus fetch this cycle |
| pq_vld | output | 1 | A word is offered to the prefetch queue |
| pq_word | output | DW | Instruction word for the prefetch queue |
| cache_hit | output | 1 | The previous cycle's jump hit the entry |

## Verification
Loops are replayed in which the closing relative jump is taken twice. Between the fill and the second pass the memory contents change, so a word sourced from the cache is told apart from one refetched from the bus. Data transfer cycles are injected right after the jump, during the fill and during the replay, which separates a pointer or fill counter that wrongly advances on them from a correct one. Intervening absolute, internal, other-redirect and different-address jumps each show whether the entry survives when it must not. The A, A+2, A+4 address order after a hit is checked both cycle by cycle against the reference model and explicitly after each replay.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic [1:0] {
    JK_REL   = 2'd0,
    JK_ABS   = 2'd1,
    JK_BIT   = 2'd2,
    JK_OTHER = 2'd3
  } jkind_e;
endpackage

// File: rtl/btc_entry.sv
module btc_entry
  import btc_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int WORDS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lookup_vld,
  input  jkind_e        lookup_kind,
  input  logic [AW-1:0] lookup_pc,
  input  logic          lookup_internal,
  input  logic          take,
  input  logic [DW-1:0] take_data,
  input  logic [(WORDS>1 ? $clog2(WORDS) : 1)-1:0] rd_idx,
  output logic          hit,
  output logic [DW-1:0] rd_word
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  logic          valid;
  logic          filling;
  logic [AW-1:0] tag;
  logic [IW-1:0] fill_idx;
  logic [DW-1:0] words [WORDS];

  logic cacheable;
  assign cacheable = (lookup_kind != JK_OTHER) && !lookup_internal;
  assign hit = lookup_vld && valid && (tag == lookup_pc) &&
               (lookup_kind == JK_REL) && !lookup_internal;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      filling  <= 1'b0;
      tag      <= '0;
      fill_idx <= '0;
    end else if (lookup_vld) begin
      if (!hit) begin
        valid    <= 1'b0;
        filling  <= cacheable;
        fill_idx <= '0;
        if (cacheable) tag <= lookup_pc;
      end
    end else if (filling && take) begin
      fill_idx <= fill_idx + 1'b1;
      if (fill_idx == LAST) begin
        filling <= 1'b0;
        valid   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (filling && take && !lookup_vld) words[fill_idx] <= take_data;
  end

  assign rd_word = words[rd_idx];

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !valid);
  p_fill_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(valid && filling));
  p_valid_after_fill_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(filling && take && fill_idx == LAST));
  p_internal_invalidates_r8: assert property (@(posedge clk) disable iff (rst)
    lookup_vld && lookup_internal |=> !valid && !filling);
endmodule

// File: rtl/btc_fetch_ptr.sv
module btc_fetch_ptr #(
  parameter int          AW         = 16,
  parameter int          DW         = 16,
  parameter int          WORDS      = 2,
  parameter logic [15:0] RESET_ADDR = 16'h0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          jmp_vld,
  input  logic          hit,
  input  logic [AW-1:0] target,
  input  logic          bus_ack,
  input  logic          bus_xfer,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_req,
  output logic          take,
  output logic          replay_act,
  output logic [(WORDS>1 ? $clog2(WORDS) : 1)-1:0] replay_idx
);
  localparam int CW = $clog2(WORDS + 1);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [AW-1:0] STEP = AW'(DW / 8);
  localparam logic [AW-1:0] ADV  = AW'(WORDS * (DW / 8));

  logic [CW-1:0] cnt;

  assign fetch_req  = (cnt == '0);
  assign replay_act = !fetch_req;
  assign take       = bus_ack && !bus_xfer && fetch_req && !jmp_vld;
  assign replay_idx = IW'(WORDS - int'(cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr <= AW'(RESET_ADDR);
      cnt        <= '0;
    end else if (jmp_vld) begin
      if (hit) begin
        fetch_addr <= target + ADV;
        cnt        <= CW'(WORDS);
      end else begin
        fetch_addr <= target;
        cnt        <= '0;
      end
    end else begin
      if (take) fetch_addr <= fetch_addr + STEP;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  p_resume_past_pair_r6: assert property (@(posedge clk) disable iff (rst)
    jmp_vld && hit |=> fetch_addr == $past(target) + ADV);
  p_xfer_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    bus_ack && bus_xfer && !jmp_vld |=> fetch_addr == $past(fetch_addr));
  p_miss_redirect_r3: assert property (@(posedge clk) disable iff (rst)
    jmp_vld && !hit |=> fetch_addr == $past(target) && fetch_req);
endmodule

// File: rtl/btc_pq_out.sv
module btc_pq_out #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kill,
  input  logic          hit_evt,
  input  logic          replay_act,
  input  logic [DW-1:0] rd_word,
  input  logic          take,
  input  logic [DW-1:0] bus_data,
  output logic          pq_vld,
  output logic [DW-1:0] pq_word,
  output logic          cache_hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pq_vld    <= 1'b0;
      pq_word   <= '0;
      cache_hit <= 1'b0;
    end else begin
      cache_hit <= hit_evt;
      if (kill) begin
        pq_vld <= 1'b0;
      end else if (replay_act) begin
        pq_vld  <= 1'b1;
        pq_word <= rd_word;
      end else if (take) begin
        pq_vld  <= 1'b1;
        pq_word <= bus_data;
      end else begin
        pq_vld <= 1'b0;
      end
    end
  end

  p_kill_drops_word_r3: assert property (@(posedge clk) disable iff (rst)
    kill |=> !pq_vld);
endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
  import btc_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DW         = 16,
  parameter logic [15:0] RESET_ADDR = 16'h0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          jmp_vld,
  input  logic [1:0]    jmp_kind,
  input  logic [AW-1:0] jmp_pc,
  input  logic [AW-1:0] jmp_target,
  input  logic          jmp_internal,
  input  logic          bus_ack,
  input  logic          bus_xfer,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_req,
  output logic          pq_vld,
  output logic [DW-1:0] pq_word,
  output logic          cache_hit
);
  localparam int WORDS = 2;
  localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  jkind_e        kind;
  logic          hit;
  logic          take;
  logic          replay_act;
  logic [IW-1:0] replay_idx;
  logic [DW-1:0] rd_word;

  assign kind = jkind_e'(jmp_kind);

  btc_entry #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_entry (
    .clk(clk), .rst(rst),
    .lookup_vld(jmp_vld), .lookup_kind(kind), .lookup_pc(jmp_pc),
    .lookup_internal(jmp_internal),
    .take(take), .take_data(bus_rdata), .rd_idx(replay_idx),
    .hit(hit), .rd_word(rd_word)
  );

  btc_fetch_ptr #(.AW(AW), .DW(DW), .WORDS(WORDS), .RESET_ADDR(RESET_ADDR)) u_ptr (
    .clk(clk), .rst(rst),
    .jmp_vld(jmp_vld), .hit(hit), .target(jmp_target),
    .bus_ack(bus_ack), .bus_xfer(bus_xfer),
    .fetch_addr(fetch_addr), .fetch_req(fetch_req), .take(take),
    .replay_act(replay_act), .replay_idx(replay_idx)
  );

  btc_pq_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst),
    .kill(jmp_vld), .hit_evt(hit), .replay_act(replay_act),
    .rd_word(rd_word), .take(take), .bus_data(bus_rdata),
    .pq_vld(pq_vld), .pq_word(pq_word), .cache_hit(cache_hit)
  );

  p_abs_never_hits_r7: assert property (@(posedge clk) disable iff (rst)
    jmp_vld && jmp_kind == 2'd1 |=> !cache_hit);
  p_internal_never_hits_r8: assert property (@(posedge clk) disable iff (rst)
    jmp_vld && jmp_internal |=> !cache_hit);
  p_other_then_miss_r9: assert property (@(posedge clk) disable iff (rst)
    jmp_vld && jmp_kind == 2'd3 ##1 jmp_vld |=> !cache_hit);
  p_replay_starts_r5: assert property (@(posedge clk) disable iff (rst)
    cache_hit && !jmp_vld |=> pq_vld && !fetch_req);
  p_no_fetch_in_replay_r5: assert property (@(posedge clk) disable iff (rst)
    cache_hit |-> !fetch_req);
endmodule

// File: tb/branch_target_cache_bench.sv
module branch_target_cache_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        jmp_vld, jmp_internal, bus_ack, bus_xfer;
  logic [1:0]  jmp_kind;
  logic [15:0] jmp_pc, jmp_target, bus_rdata;
  logic [15:0] fetch_addr, pq_word;
  logic        fetch_req, pq_vld, cache_hit;

  int checks = 0;
  int fails  = 0;
  int gen    = 0;

  // behavioural reference state
  int m_ptr, m_rep, m_tag, m_w0, m_w1, m_fill;
  bit m_vld, m_pqv, m_hit;
  int m_pqw;

  always #5 clk = ~clk;

  branch_target_cache #(.AW(16), .DW(16), .RESET_ADDR(16'h0080)) u_branch_target_cache (
    .clk(clk), .rst(rst),
    .jmp_vld(jmp_vld), .jmp_kind(jmp_kind), .jmp_pc(jmp_pc),
    .jmp_target(jmp_target), .jmp_internal(jmp_internal),
    .bus_ack(bus_ack), .bus_xfer(bus_xfer), .bus_rdata(bus_rdata),
    .fetch_addr(fetch_addr), .fetch_req(fetch_req),
    .pq_vld(pq_vld), .pq_word(pq_word), .cache_hit(cache_hit)
  );

  function automatic int mem(int a, int g);
    return ((a * 5) ^ (g * 16'h1111) ^ 16'h3C00) & 16'hFFFF;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: compare outputs, drive inputs, advance the model
  task automatic cyc(bit jv, int kind, int pc, int tgt, bit intl, bit ack, bit xfer);
    bit hit, take, cacheable;
    int rdata;
    @(negedge clk);
    chk(fetch_addr == 16'(m_ptr), "R3 fetch_addr", fetch_addr, m_ptr);
    chk(fetch_req == (m_rep == 0), "R5 fetch_req", fetch_req, m_rep == 0);
    chk(pq_vld == m_pqv, "R2 pq_vld", pq_vld, m_pqv);
    if (m_pqv) chk(pq_word == 16'(m_pqw), "R2 pq_word", pq_word, m_pqw);
    chk(cache_hit == m_hit, "R5 cache_hit", cache_hit, m_hit);
    rdata        = mem(m_ptr, gen);
    jmp_vld      = jv;
    jmp_kind     = 2'(kind);
    jmp_pc       = 16'(pc);
    jmp_target   = 16'(tgt);
    jmp_internal = intl;
    bus_ack      = ack;
    bus_xfer     = xfer;
    bus_rdata    = 16'(rdata);
    hit  = jv && m_vld && m_tag == pc && kind == 0 && !intl;
    take = ack && !xfer && m_rep == 0 && !jv;
    cacheable = kind != 3 && !intl;
    m_hit = hit;
    if (jv) m_pqv = 0;
    else if (m_rep > 0) begin m_pqv = 1; m_pqw = (m_rep == 2) ? m_w0 : m_w1; end
    else if (take) begin m_pqv = 1; m_pqw = rdata; end
    else m_pqv = 0;
    if (jv) begin
      m_ptr = hit ? (tgt + 4) & 16'hFFFF : tgt;
      m_rep = hit ? 2 : 0;
      if (!hit) begin
        m_vld = 0;
        m_fill = cacheable ? 0 : -1;
        if (cacheable) m_tag = pc;
      end
    end else begin
      if (take) begin
        m_ptr = (m_ptr + 2) & 16'hFFFF;
        if (m_fill == 0) begin m_w0 = rdata; m_fill = 1; end
        else if (m_fill == 1) begin m_w1 = rdata; m_fill = -1; m_vld = 1; end
      end
      if (m_rep > 0) m_rep--;
    end
  endtask

  task automatic fetch_n(int n, int xfer_every);
    for (int i = 0; i < n; i++)
      cyc(0, 0, 0, 0, 0, 1, xfer_every > 0 && (i % xfer_every) == 1);
  endtask

  task automatic jmp(int kind, int pc, int tgt, bit intl);
    cyc(1, kind, pc, tgt, intl, 1, 0);
  endtask

  // hit then replay: cached words from generation g0, resume at tgt+4
  task automatic expect_hit(int pc, int tgt, int g0);
    jmp(0, pc, tgt, 0);
    cyc(0, 0, 0, 0, 0, 1, 1);
    chk(cache_hit == 1'b1, "R5 hit pulse", cache_hit, 1);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk(pq_word == 16'(mem(tgt, g0)), "R5 word A", pq_word, mem(tgt, g0));
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk(pq_word == 16'(mem(tgt + 2, g0)), "R5 word A+2", pq_word, mem(tgt + 2, g0));
    chk(fetch_addr == 16'(tgt + 4) && fetch_req, "R6 resume at A+4", fetch_addr, tgt + 4);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk(pq_word == 16'(mem(tgt + 4, gen)), "R6 bus word A+4", pq_word, mem(tgt + 4, gen));
  endtask

  task automatic expect_miss(int kind, int pc, int tgt, bit intl, string req);
    jmp(kind, pc, tgt, intl);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk(cache_hit == 1'b0, req, cache_hit, 0);
    chk(fetch_addr == 16'(tgt) && fetch_req, req, fetch_addr, tgt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int g;
    rst = 1; jmp_vld = 0; jmp_kind = 0; jmp_pc = 0; jmp_target = 0;
    jmp_internal = 0; bus_ack = 0; bus_xfer = 0; bus_rdata = 0;
    m_ptr = 16'h0080; m_rep = 0; m_tag = 0; m_w0 = 0; m_w1 = 0; m_fill = -1;
    m_vld = 0; m_pqv = 0; m_hit = 0; m_pqw = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(fetch_addr == 16'h0080 && fetch_req && !pq_vld && !cache_hit,
        "R1 reset state", fetch_addr, 16'h0080);
    // R2 sequential fetching, R10 transfer cycles in between
    fetch_n(6, 0);
    fetch_n(6, 3);
    // R4 fill then R5/R6 hit, memory changed in between
    jmp(0, 16'h0140, 16'h0100, 0);
    fetch_n(5, 2);
    g = gen; gen++;
    fetch_n(3, 0);
    expect_hit(16'h0140, 16'h0100, g);
    // second pass of the same loop hits again
    fetch_n(4, 0);
    expect_hit(16'h0140, 16'h0100, g);
    // R10 transfer cycle right after the jump must not disturb the fill
    jmp(0, 16'h0250, 16'h0200, 0);
    cyc(0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1, 1);
    fetch_n(4, 0);
    g = gen; gen++;
    expect_hit(16'h0250, 16'h0200, g);
    // R7 absolute kind reloads but never hits
    jmp(1, 16'h0330, 16'h0300, 0);
    fetch_n(3, 0);
    expect_miss(1, 16'h0330, 16'h0300, 0, "R7 absolute no hit");
    // R8 internal code: no hit, and entry left invalid
    jmp(0, 16'h0440, 16'h0400, 0);
    fetch_n(3, 0);
    expect_miss(0, 16'h0440, 16'h0400, 1, "R8 internal no hit");
    fetch_n(3, 0);
    expect_miss(0, 16'h0440, 16'h0400, 0, "R8 entry invalidated");
    // R9 other redirect invalidates a full entry
    fetch_n(3, 0);
    jmp(3, 16'h0000, 16'h0600, 0);
    fetch_n(2, 0);
    expect_miss(0, 16'h0440, 16'h0400, 0, "R9 other redirect");
    // R9 other redirect aborts a fill after one word
    jmp(0, 16'h0540, 16'h0500, 0);
    fetch_n(1, 0);
    jmp(3, 16'h0000, 16'h0700, 0);
    fetch_n(4, 0);
    expect_miss(0, 16'h0540, 16'h0500, 0, "R9 fill aborted");
    // R11 a different jump replaces the entry; bit-test kind also loads
    fetch_n(3, 0);
    jmp(0, 16'h0860, 16'h0800, 0);
    fetch_n(3, 0);
    expect_miss(0, 16'h0540, 16'h0500, 0, "R11 replaced entry");
    fetch_n(3, 0);
    jmp(2, 16'h0970, 16'h0900, 0);
    fetch_n(3, 0);
    expect_miss(0, 16'h0860, 16'h0800, 0, "R11 bit-test reload");
    // R3 jump during a replay cancels it and redirects
    fetch_n(3, 0);
    g = gen;
    expect_hit(16'h0860, 16'h0800, g);
    fetch_n(2, 0);
    jmp(0, 16'h0860, 16'h0800, 0);
    jmp(3, 16'h0000, 16'h0A00, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk(!pq_vld && fetch_addr == 16'h0A00, "R3 replay cancelled", fetch_addr, 16'h0A00);
    fetch_n(4, 2);
    cyc(0, 0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule